// File: doc/BRIEF.md
# Day-and-Seconds Real-Time Clock with Alarm

This block keeps wall-clock time as a 15-bit day number plus a 17-bit time of day in seconds. An external 1 Hz enable (`tick_i`) advances the count. The time of day is stored in two registers that software can write separately: a low byte and a 9-bit upper part. A matching set of three alarm registers uses the same encoding. When the running time becomes equal to the alarm time the block latches an alarm flag. Every tick also latches an update flag. Each flag has its own enable, and the interrupt output is raised while any enabled flag is set.

Software reaches the block through a single-cycle register port: a write strobe, a 3-bit offset and 16-bit write data, with read data returned combinationally for the offset presented. The seconds value is split across two registers, so software has to follow a carry-safe sequence. To set the time it writes the low byte to zero, then the day, the upper part and finally the low byte. To read the time it reads the upper part, the day, the low byte and the upper part again, and reads the day once more if the upper part went down between the two reads.

The design has three small engines under the top. The first is the time counter, whose per-cycle action is one of four named actions: HOLD, STEP, WRAP or LOAD. The second is the alarm tracker, a two-state machine. WATCH moves to HELD on a match, and that transition fires the alarm. HELD moves back to WATCH when the time and the alarm no longer match. In every other case each state stays where it is. Reset enters HELD. The third is the interrupt status and enable register pair.

Top module: `daysec_rtc`

## Requirements
- R1: Reset clears all eight registers to zero and deasserts `irq_o`. An alarm match that is present when reset ends does not set the alarm flag.
- R2: The register offsets are 0 time-of-day low (bits 7:0), 1 time-of-day upper (bits 8:0), 2 day (bits 14:0), 3 alarm low, 4 alarm upper, 5 alarm day (the same widths), 6 interrupt enable and 7 interrupt status (bit 0 alarm, bit 1 update). Write-data bits above a field are dropped and read back as zero. Time of day = low + upper*256.
- R3: A tick with no time-register write in the same cycle increments the time of day by one. A low byte of 255 carries into the upper part, and the day is unchanged.
- R4: A tick when the time of day is 86399 or more sets the time of day to 0 and increments the day. Day 32767 wraps to 0.
- R5: A write to offset 0, 1 or 2 in a tick cycle cancels that advance. The written field takes the write data and the other time fields keep their values. A write to any other offset does not cancel the tick.
- R6: The alarm flag (status bit 0) is set one cycle after the time first equals the alarm time. It is not set again until the two have differed for at least one cycle. A write that creates a match also fires the alarm.
- R7: Every tick sets the update flag (status bit 1) at the same clock edge, even when a write cancels the advance.
- R8: Status bits are sticky. Writing 1 to a bit of offset 7 clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `irq_o` equals (status[0] AND enable[0]) OR (status[1] AND enable[1]), with no added delay.
- R10: While ticks keep arriving, the sequence "low := 0, day, upper, low" leaves exactly the written day, upper and low values right after the final write.
- R11: While ticks keep arriving, the read sequence "upper, day, low, upper, then day again if upper decreased" returns the correct time across a day carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds advance enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, zero-extended |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps 600 consecutive ticks across a day boundary, including low-byte carries, and compares every step with an arithmetic model. A wrong end-of-day limit or a lost carry into the upper part therefore shows up as a count that runs past 86399 or jumps by 256. It forces the day wrap from 32767, and it sets a time of day above the legal range to show that the wrap comparison is "at or above", not "equal". It drives writes in tick cycles, where a design that lets the tick run alongside the write would leave the low byte one off or bump an unwritten field. It tests repeated alarm firing during one match, a set and a clear in the same cycle, and all four enable patterns against each status pattern. Finally it runs the carry-safe write and read sequences while the clock keeps ticking.

// File: rtl/daysec_pkg.sv
package daysec_pkg;

    localparam int unsigned RTC_LO_W        = 8;
    localparam int unsigned RTC_HI_W        = 9;
    localparam int unsigned RTC_DAY_W       = 15;
    localparam int unsigned RTC_DATA_W      = 16;
    localparam int unsigned RTC_ADDR_W      = 3;
    localparam int unsigned RTC_DAY_SECONDS = 86400;
    localparam int unsigned RTC_IRQ_N       = 2;
    localparam int unsigned IRQ_ALM_BIT     = 0;
    localparam int unsigned IRQ_UPD_BIT     = 1;

    typedef enum logic [RTC_ADDR_W-1:0] {
        REG_TOD_LO   = 3'd0,
        REG_TOD_HI   = 3'd1,
        REG_DAY      = 3'd2,
        REG_ALM_LO   = 3'd3,
        REG_ALM_HI   = 3'd4,
        REG_ALM_DAY  = 3'd5,
        REG_IRQ_EN   = 3'd6,
        REG_IRQ_STAT = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_STEP,
        CNT_WRAP,
        CNT_LOAD
    } cnt_act_e;

    typedef enum logic {
        ALM_WATCH,
        ALM_HELD
    } alm_state_e;

endpackage

// File: rtl/daysec_counter.sv
module daysec_counter
    import daysec_pkg::*;
#(
    parameter int unsigned LO_W        = RTC_LO_W,
    parameter int unsigned HI_W        = RTC_HI_W,
    parameter int unsigned DAY_W       = RTC_DAY_W,
    parameter int unsigned DAY_SECONDS = RTC_DAY_SECONDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             wr_day_i,
    input  logic [DAY_W-1:0] wdata_i,
    output logic [LO_W-1:0]  tod_lo_o,
    output logic [HI_W-1:0]  tod_hi_o,
    output logic [DAY_W-1:0] day_o
);

    localparam int unsigned      TOD_W    = LO_W + HI_W;
    localparam logic [TOD_W-1:0] TOD_LAST = TOD_W'(DAY_SECONDS - 1);

    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_q;
    logic [DAY_W-1:0] day_q;
    logic [TOD_W-1:0] tod;
    logic [TOD_W-1:0] tod_inc;
    logic             wr_any;
    cnt_act_e         act;

    assign tod     = {hi_q, lo_q};
    assign tod_inc = tod + TOD_W'(1);
    assign wr_any  = wr_lo_i | wr_hi_i | wr_day_i;

    // Action select: a write outranks the tick in the same cycle.
    always_comb begin
        if (wr_any) begin
            act = CNT_LOAD;
        end else if (tick_i) begin
            act = (tod >= TOD_LAST) ? CNT_WRAP : CNT_STEP;
        end else begin
            act = CNT_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            day_q <= '0;
        end else begin
            unique case (act)
                CNT_HOLD: begin
                    lo_q <= lo_q;
                end
                CNT_STEP: begin
                    {hi_q, lo_q} <= tod_inc;
                end
                CNT_WRAP: begin
                    lo_q  <= '0;
                    hi_q  <= '0;
                    day_q <= day_q + DAY_W'(1);
                end
                CNT_LOAD: begin
                    if (wr_lo_i)  lo_q  <= wdata_i[LO_W-1:0];
                    if (wr_hi_i)  hi_q  <= wdata_i[HI_W-1:0];
                    if (wr_day_i) day_q <= wdata_i;
                end
                default: begin
                    lo_q <= lo_q;
                end
            endcase
        end
    end

    assign tod_lo_o = lo_q;
    assign tod_hi_o = hi_q;
    assign day_o    = day_q;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_any && (tod < TOD_LAST)) |=>
        (tod == TOD_W'($past(tod) + TOD_W'(1))) && $stable(day_q)); // R3

    AST_DAY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_any && (tod >= TOD_LAST)) |=>
        (tod == '0) && (day_q == DAY_W'($past(day_q) + DAY_W'(1)))); // R4

    AST_WRITE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && tick_i) |=> $stable(hi_q) && $stable(day_q)); // R5

endmodule

// File: rtl/daysec_alarm.sv
module daysec_alarm
    import daysec_pkg::*;
#(
    parameter int unsigned LO_W  = RTC_LO_W,
    parameter int unsigned HI_W  = RTC_HI_W,
    parameter int unsigned DAY_W = RTC_DAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             wr_day_i,
    input  logic [DAY_W-1:0] wdata_i,
    input  logic [LO_W-1:0]  cur_lo_i,
    input  logic [HI_W-1:0]  cur_hi_i,
    input  logic [DAY_W-1:0] cur_day_i,
    output logic [LO_W-1:0]  alm_lo_o,
    output logic [HI_W-1:0]  alm_hi_o,
    output logic [DAY_W-1:0] alm_day_o,
    output logic             hit_o
);

    logic [LO_W-1:0]  alm_lo_q;
    logic [HI_W-1:0]  alm_hi_q;
    logic [DAY_W-1:0] alm_day_q;
    logic             match;
    alm_state_e       state_q;
    alm_state_e       state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_lo_q  <= '0;
            alm_hi_q  <= '0;
            alm_day_q <= '0;
        end else begin
            if (wr_lo_i)  alm_lo_q  <= wdata_i[LO_W-1:0];
            if (wr_hi_i)  alm_hi_q  <= wdata_i[HI_W-1:0];
            if (wr_day_i) alm_day_q <= wdata_i;
        end
    end

    assign match = (alm_lo_q == cur_lo_i) && (alm_hi_q == cur_hi_i)
                && (alm_day_q == cur_day_i);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_WATCH: if (match)  state_d = ALM_HELD;
            ALM_HELD:  if (!match) state_d = ALM_WATCH;
            default:   state_d = ALM_HELD;
        endcase
    end

    // State register; reset parks in HELD so a match at reset is not an event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_HELD;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        hit_o = 1'b0;
        unique case (state_q)
            ALM_WATCH: hit_o = match;
            ALM_HELD:  hit_o = 1'b0;
            default:   hit_o = 1'b0;
        endcase
    end

    assign alm_lo_o  = alm_lo_q;
    assign alm_hi_o  = alm_hi_q;
    assign alm_day_o = alm_day_q;

    AST_ALARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o); // R6

endmodule

// File: rtl/daysec_irq.sv
module daysec_irq
    import daysec_pkg::*;
#(
    parameter int unsigned IRQ_N = RTC_IRQ_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alm_set_i,
    input  logic             upd_set_i,
    input  logic             wr_en_i,
    input  logic             wr_stat_i,
    input  logic [IRQ_N-1:0] wdata_i,
    output logic [IRQ_N-1:0] en_o,
    output logic [IRQ_N-1:0] stat_o,
    output logic             irq_o
);

    logic [IRQ_N-1:0] en_q;
    logic [IRQ_N-1:0] stat_q;
    logic [IRQ_N-1:0] set_vec;
    logic [IRQ_N-1:0] clr_vec;

    always_comb begin
        set_vec              = '0;
        set_vec[IRQ_ALM_BIT] = alm_set_i;
        set_vec[IRQ_UPD_BIT] = upd_set_i;
    end

    assign clr_vec = wr_stat_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en_i) en_q <= wdata_i;
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_q);

    AST_UPD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_set_i |=> stat_q[IRQ_UPD_BIT]); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[IRQ_ALM_BIT] && !(wr_stat_i && wdata_i[IRQ_ALM_BIT]))
        |=> stat_q[IRQ_ALM_BIT]); // R8

endmodule

// File: rtl/daysec_rtc.sv
module daysec_rtc
    import daysec_pkg::*;
#(
    parameter int unsigned LO_W        = RTC_LO_W,
    parameter int unsigned HI_W        = RTC_HI_W,
    parameter int unsigned DAY_W       = RTC_DAY_W,
    parameter int unsigned DATA_W      = RTC_DATA_W,
    parameter int unsigned ADDR_W      = RTC_ADDR_W,
    parameter int unsigned DAY_SECONDS = RTC_DAY_SECONDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int unsigned IRQ_N = RTC_IRQ_N;

    reg_sel_e         sel;
    logic             wr_tlo, wr_thi, wr_tday;
    logic             wr_alo, wr_ahi, wr_aday;
    logic             wr_en, wr_stat;
    logic [LO_W-1:0]  t_lo, a_lo;
    logic [HI_W-1:0]  t_hi, a_hi;
    logic [DAY_W-1:0] t_day, a_day;
    logic [IRQ_N-1:0] irq_en, irq_stat;
    logic             alm_hit;
    logic             unused_wbits;

    assign sel          = reg_sel_e'(addr_i);
    assign unused_wbits = ^wdata_i[DATA_W-1:DAY_W];

    always_comb begin
        {wr_tlo, wr_thi, wr_tday, wr_alo, wr_ahi, wr_aday, wr_en, wr_stat} = '0;
        if (wr_i) begin
            unique case (sel)
                REG_TOD_LO:   wr_tlo  = 1'b1;
                REG_TOD_HI:   wr_thi  = 1'b1;
                REG_DAY:      wr_tday = 1'b1;
                REG_ALM_LO:   wr_alo  = 1'b1;
                REG_ALM_HI:   wr_ahi  = 1'b1;
                REG_ALM_DAY:  wr_aday = 1'b1;
                REG_IRQ_EN:   wr_en   = 1'b1;
                REG_IRQ_STAT: wr_stat = 1'b1;
                default:      wr_en   = 1'b0;
            endcase
        end
    end

    daysec_counter #(
        .LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W), .DAY_SECONDS(DAY_SECONDS)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_lo_i  (wr_tlo),
        .wr_hi_i  (wr_thi),
        .wr_day_i (wr_tday),
        .wdata_i  (wdata_i[DAY_W-1:0]),
        .tod_lo_o (t_lo),
        .tod_hi_o (t_hi),
        .day_o    (t_day)
    );

    daysec_alarm #(
        .LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo_i   (wr_alo),
        .wr_hi_i   (wr_ahi),
        .wr_day_i  (wr_aday),
        .wdata_i   (wdata_i[DAY_W-1:0]),
        .cur_lo_i  (t_lo),
        .cur_hi_i  (t_hi),
        .cur_day_i (t_day),
        .alm_lo_o  (a_lo),
        .alm_hi_o  (a_hi),
        .alm_day_o (a_day),
        .hit_o     (alm_hit)
    );

    daysec_irq #(
        .IRQ_N(IRQ_N)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alm_set_i (alm_hit),
        .upd_set_i (tick_i),
        .wr_en_i   (wr_en),
        .wr_stat_i (wr_stat),
        .wdata_i   (wdata_i[IRQ_N-1:0]),
        .en_o      (irq_en),
        .stat_o    (irq_stat),
        .irq_o     (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_TOD_LO:   rdata_o = DATA_W'(t_lo);
            REG_TOD_HI:   rdata_o = DATA_W'(t_hi);
            REG_DAY:      rdata_o = DATA_W'(t_day);
            REG_ALM_LO:   rdata_o = DATA_W'(a_lo);
            REG_ALM_HI:   rdata_o = DATA_W'(a_hi);
            REG_ALM_DAY:  rdata_o = DATA_W'(a_day);
            REG_IRQ_EN:   rdata_o = DATA_W'(irq_en);
            REG_IRQ_STAT: rdata_o = DATA_W'(irq_stat);
            default:      rdata_o = '0;
        endcase
    end

endmodule

// File: tb/sim_daysec_rtc.sv
module sim_daysec_rtc;

    localparam int CLK_PERIOD = 10;
    localparam int DAYSEC     = 86400;
    localparam int DAYS       = 32768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    daysec_rtc u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        cyc();
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic rd_time(output int d, output int t);
        logic [15:0] lo, hi, dy;
        rd(3'd0, lo); rd(3'd1, hi); rd(3'd2, dy);
        t = int'(hi) * 256 + int'(lo);
        d = int'(dy);
    endtask

    task automatic set_time(input int d, input int t);
        wr(3'd0, 16'(t % 256));
        wr(3'd1, 16'(t / 256));
        wr(3'd2, 16'(d));
    endtask

    initial begin
        logic [15:0] v, h1, h2, dd, ll;
        int ed, et, gd, gt;

        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(); cyc();
        for (int g = 0; g < 2; g++) begin
            for (int a = 0; a < 4; a++) begin
                rd(3'(g * 4 + a), v);
                chk($sformatf("R1 reset reg %0d", g * 4 + a), v, 0);
            end
            cyc();
        end
        chk("R1 reset irq", irq_o, 0);
        rd(3'd7, v);
        chk("R1 no alarm from match at reset", v, 0);

        // Field widths and layout
        for (int a = 0; a < 7; a++) wr(3'(a), 16'hFFFF);
        rd(3'd0, v); chk("R2 tod low width", v, 16'h00FF);
        rd(3'd1, v); chk("R2 tod upper width", v, 16'h01FF);
        rd(3'd2, v); chk("R2 day width", v, 16'h7FFF);
        rd(3'd3, v); chk("R2 alarm low width", v, 16'h00FF);
        cyc();
        rd(3'd4, v); chk("R2 alarm upper width", v, 16'h01FF);
        rd(3'd5, v); chk("R2 alarm day width", v, 16'h7FFF);
        rd(3'd6, v); chk("R2 enable width", v, 16'h0003);
        wr(3'd6, 16'h0000);
        // out-of-range TOD wraps at the next tick
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R4 above-range tod wraps", gt, 0);
        chk("R4 day 32767 wraps to 0", gd, 0);
        wr(3'd7, 16'h0003);

        // Sweep across a day boundary
        ed = 5; et = DAYSEC - 300;
        set_time(ed, et);
        wr(3'd5, 16'd100);
        tick_i = 1'b1;
        for (int i = 0; i < 600; i++) begin
            cyc();
            if (et >= DAYSEC - 1) begin et = 0; ed = (ed + 1) % DAYS; end
            else et = et + 1;
            rd_time(gd, gt);
            chk($sformatf("R3 R4 sweep step %0d tod", i), gt, et);
            chk($sformatf("R3 R4 sweep step %0d day", i), gd, ed);
        end
        tick_i = 1'b0;

        // Day wrap
        set_time(DAYS - 1, DAYSEC - 2);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R4 last second tod", gt, DAYSEC - 1);
        chk("R4 last second day", gd, DAYS - 1);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R4 day wrap tod", gt, 0);
        chk("R4 day wrap day", gd, 0);

        // Write versus tick
        set_time(1, 256);
        tick_i = 1'b1; wr(3'd0, 16'h0020); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R5 low write wins over tick", gt, 256 + 32);
        chk("R5 day untouched", gd, 1);
        tick_i = 1'b1; wr(3'd6, 16'h0000); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R5 enable write does not cancel tick", gt, 256 + 33);
        tick_i = 1'b1; wr(3'd1, 16'h0003); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R5 upper write keeps low byte", gt, 3 * 256 + 33);

        // Update flag and write-1-to-clear
        wr(3'd7, 16'h0003);
        rd(3'd7, v); chk("R8 cleared status", v, 0);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd(3'd7, v); chk("R7 update flag after tick", v, 2);
        wr(3'd7, 16'h0000);
        rd(3'd7, v); chk("R8 writing zero keeps flag", v, 2);
        tick_i = 1'b1; wr(3'd7, 16'h0002); tick_i = 1'b0;
        rd(3'd7, v); chk("R8 set wins over clear", v, 2);
        wr(3'd7, 16'h0002);
        rd(3'd7, v); chk("R8 clear update flag", v, 0);
        tick_i = 1'b1; wr(3'd0, 16'h0000); tick_i = 1'b0;
        rd(3'd7, v); chk("R7 flag on cancelled tick", v, 2);

        // Alarm
        wr(3'd5, 16'd2); wr(3'd4, 16'd0); wr(3'd3, 16'd100);
        set_time(2, 97);
        wr(3'd7, 16'h0003);
        tick_i = 1'b1; cyc(); cyc(); cyc(); tick_i = 1'b0;
        rd(3'd7, v); chk("R6 alarm not yet set", v & 1, 0);
        cyc();
        rd(3'd7, v); chk("R6 alarm set one cycle after match", v & 1, 1);
        wr(3'd7, 16'h0001);
        cyc();
        rd(3'd7, v); chk("R6 no refire during same match", v & 1, 0);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        wr(3'd0, 16'd100);
        cyc();
        rd(3'd7, v); chk("R6 write-created match fires", v, 3);

        // Interrupt masking
        for (int e = 0; e < 4; e++) begin
            wr(3'd6, 16'(e));
            chk($sformatf("R9 both flags en=%0d", e), irq_o, (e != 0) ? 1 : 0);
        end
        wr(3'd7, 16'h0001);
        for (int e = 0; e < 4; e++) begin
            wr(3'd6, 16'(e));
            chk($sformatf("R9 update only en=%0d", e), irq_o, (e >> 1) & 1);
        end
        wr(3'd7, 16'h0002);
        chk("R9 no flags", irq_o, 0);
        wr(3'd6, 16'h0000);

        // Carry-safe set sequence with ticks running
        set_time(7, 16'h10F0);
        tick_i = 1'b1;
        wr(3'd0, 16'd0);
        wr(3'd2, 16'd9);
        wr(3'd1, 16'h0020);
        wr(3'd0, 16'h0033);
        tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R10 exact tod after sequence", gt, 16'h2033);
        chk("R10 exact day after sequence", gd, 9);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd_time(gd, gt);
        chk("R10 counting resumes", gt, 16'h2034);

        // Carry-safe read sequence across a day carry
        set_time(3, DAYSEC - 1);
        rd(3'd1, h1);
        rd(3'd2, dd);
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
        rd(3'd0, ll);
        rd(3'd1, h2);
        chk("R11 upper decrease detected", (h2 < h1) ? 1 : 0, 1);
        if (h2 < h1) rd(3'd2, dd);
        chk("R11 assembled time",
            longint'(dd) * DAYSEC + longint'(h2) * 256 + longint'(ll),
            longint'(3) * DAYSEC + DAYSEC);

        finish_run();
    end

endmodule